// File: doc/BRIEF.md
# T1 Transmit Elastic Slip Buffer

This block is a two-frame elastic store between a system-side serial stream and a line-side transmit stream. The system side delivers 32 eight-bit time slots per 125 µs frame on the system clock. The line side reads 24 channels plus one framing-bit position per frame on an unrelated transmit clock. Bytes are stored by slot into a ring of two frames. The reader sends channel `c` from slot `c` of its current frame, MSB first. The framing-bit position is flagged and driven low, because framing content is added further down the line.

The two clocks drift apart. The reader therefore checks its distance to the writer each time it starts a frame, and keeps whole frames intact by slipping a full frame when the writer is too close.
- If the writer is just ahead, the reader rereads the frame it has just sent. This is a repeat.
- If the writer is about to lap the reader, the reader jumps to the newest frame. This is a drop.

Each slip flips a toggle bit and records whether it was a repeat or a drop.

In the system domain, the block measures the write position at each read frame start, relative to the frame being read. The result is split into a slot count, a bit count and a greater-than-one-frame MSB. These three fields are published together once every two write frames (250 µs). A host write strobe clears the MSB.

Top module: `tx_slip_buffer`

## Requirements
- R1: While both resets are low, the outputs are as follows: `tx_fslot`=1, `tx_data`=0, `slip_tog`=0, `slip_rep`=0, and `dly_slots`, `dly_bits` and `dly_msb` are all 0. Reset puts the writer at slot 0 of frame 0 and the reader at the framing position of frame 1, which is one frame apart.
- R2: Each read frame is 1+8·CHANS transmit bits long. Bit 0 is the framing position (`tx_fslot`=1, `tx_data`=0). Bits 1+8c to 8+8c carry the byte written to slot c, MSB first. All channels of one read frame come from the same write frame.
- R3: At a read frame start, the reader measures the writer's offset from the start of the next frame, in slots modulo 2·SLOTS. If that offset is below MARGIN, the reader rereads the previous frame and sets `slip_rep`=1.
- R4: If that offset exceeds 2·SLOTS−MARGIN−(SLOTS−CHANS), the reader reads the newest frame, skipping one frame, and sets `slip_rep`=0.
- R5: `slip_tog` inverts once for every slip, only at the start of a frame (`tx_fslot`=1), and holds otherwise.
- R6: `slip_rep` changes only together with a `slip_tog` inversion.
- R7: Each read frame start captures the write position relative to that read frame's start, in system bit times modulo two frames. The capture lags by up to 4 bit times. In the published fields, {`dly_msb`,`dly_slots`,`dly_bits`} forms that 9-bit value, with `dly_bits` in the low 3 bits.
- R8: The three delay fields update together only at the wrap of the two-frame write ring, which is every 2·SLOTS·8 system clocks. Between updates they hold, except for R9.
- R9: `dly_msb` is 1 when the published delay is one frame or more. A one-cycle `stat_clr` pulse clears it on the next clock and leaves the other fields unchanged.
- R10: When the transmit clock runs at exactly (1+8·CHANS)/(8·SLOTS) of the system clock, no slip occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System-side bit clock |
| sys_rst_n | input | 1 | System-domain reset, active low, asynchronous assert |
| sys_data | input | 1 | Serial write data, MSB of each slot first |
| stat_clr | input | 1 | Host write strobe to the delay status; clears `dly_msb` |
| dly_slots | output | $clog2(SLOTS) | Published delay, whole slots |
| dly_bits | output | 3 | Published delay, extra bit times |
| dly_msb | output | 1 | Published delay is one frame or more |
| tx_clk | input | 1 | Line-side transmit bit clock |
| tx_rst_n | input | 1 | Transmit-domain reset, active low, asynchronous assert |
| tx_data | output | 1 | Serial transmit data |
| tx_fslot | output | 1 | High during the framing-bit position |
| slip_tog | output | 1 | Inverts on each frame slip (transmit domain) |
| slip_rep | output | 1 | Last slip repeated (1) or dropped (0) a frame (transmit domain) |

## Verification
The bench builds the block with its default values: SLOTS=32, CHANS=24 and MARGIN=2. With these values the drop threshold sits at an offset of 54 slots, and a transmit clock about 5 % fast or 3.7 % slow reaches a slip within roughly 20 frames. That puts a repeat, a drop and a matched-rate run with no slip within a short run. Each scenario covers several 250 µs publications, so the bench can check the delay value on both sides of the one-frame MSB. It can also clear the MSB while it is set.

// File: rtl/tx_slip_buffer.sv
module tx_slip_buffer #(
  parameter int SLOTS  = 32,
  parameter int CHANS  = 24,
  parameter int MARGIN = 2
) (
  input  logic                     sys_clk,
  input  logic                     sys_rst_n,
  input  logic                     sys_data,
  input  logic                     stat_clr,
  output logic [$clog2(SLOTS)-1:0] dly_slots,
  output logic [2:0]               dly_bits,
  output logic                     dly_msb,
  input  logic                     tx_clk,
  input  logic                     tx_rst_n,
  output logic                     tx_data,
  output logic                     tx_fslot,
  output logic                     slip_tog,
  output logic                     slip_rep
);
  localparam int SW    = $clog2(SLOTS);
  localparam int PW    = SW + 1;
  localparam int FBITS = CHANS * 8 + 1;
  localparam int CW    = $clog2(FBITS);
  localparam int HI    = 2 * SLOTS - MARGIN - (SLOTS - CHANS);

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [7:0]    mem [2*SLOTS];
  logic [2:0]    wbit;
  logic [PW-1:0] wpos, wgray;
  logic [6:0]    wsh;
  logic [2:0]    bs;
  logic [1:0]    fs;
  logic [PW+2:0] pend;
  logic [PW-1:0] g1, g2, wbin, gap;
  logic [CW-1:0] rcnt, idx;
  logic          rfrm, rtog;
  logic [7:0]    rbyte;

  wire wrap    = (wbit == 3'd7) && (wpos == {PW{1'b1}});
  wire rd_seen = bs[2] ^ bs[1];

  always_ff @(posedge sys_clk)
    if (wbit == 3'd7) mem[wpos] <= {wsh, sys_data};

  always_ff @(posedge sys_clk or negedge sys_rst_n)
    if (!sys_rst_n) begin
      wbit <= '0; wpos <= '0; wgray <= '0; wsh <= '0;
      bs <= '0; fs <= '0; pend <= '0;
      dly_msb <= 1'b0; dly_slots <= '0; dly_bits <= '0;
    end else begin
      wbit  <= wbit + 3'd1;
      wsh   <= {wsh[5:0], sys_data};
      if (wbit == 3'd7) wpos <= wpos + 1'b1;
      wgray <= wpos ^ (wpos >> 1);
      bs    <= {bs[1:0], rtog};
      fs    <= {fs[0], rfrm};
      if (rd_seen) pend <= {wpos[SW] ^ fs[1], wpos[SW-1:0], wbit};
      if (wrap) {dly_msb, dly_slots, dly_bits} <= pend;
      else if (stat_clr) dly_msb <= 1'b0;
    end

  assign wbin = g2b(g2);
  assign gap  = wbin - {~rfrm, {SW{1'b0}}};
  wire last = rcnt == CW'(FBITS - 1);
  wire rep  = gap < PW'(MARGIN);
  wire drp  = gap > PW'(HI);

  always_ff @(posedge tx_clk or negedge tx_rst_n)
    if (!tx_rst_n) begin
      g1 <= '0; g2 <= '0; rcnt <= '0; rfrm <= 1'b1; rtog <= 1'b0;
      slip_tog <= 1'b0; slip_rep <= 1'b0;
    end else begin
      g1   <= wgray;
      g2   <= g1;
      rcnt <= last ? '0 : rcnt + 1'b1;
      if (last) begin
        rtog <= ~rtog;
        if (rep || drp) begin
          slip_tog <= ~slip_tog;
          slip_rep <= rep;
        end else begin
          rfrm <= ~rfrm;
        end
      end
    end

  assign idx      = rcnt - 1'b1;
  assign rbyte    = mem[{rfrm, SW'(idx >> 3)}];
  assign tx_fslot = rcnt == '0;
  assign tx_data  = !tx_fslot && rbyte[~idx[2:0]];

  // R2
  wgray_step_chk: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    $countones(wgray ^ $past(wgray)) <= 1);

  // R2
  frame_hold_chk: assert property (@(posedge tx_clk) disable iff (!tx_rst_n)
    !tx_fslot |-> $stable(rfrm));

  // R5
  slip_edge_chk: assert property (@(posedge tx_clk) disable iff (!tx_rst_n)
    (slip_tog != $past(slip_tog)) |-> tx_fslot);

  // R6
  dir_hold_chk: assert property (@(posedge tx_clk) disable iff (!tx_rst_n)
    (slip_tog == $past(slip_tog)) |-> $stable(slip_rep));

  // R8
  pub_hold_chk: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    !$past(wrap) |-> $stable({dly_slots, dly_bits}));

  // R9
  msb_clr_chk: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    (stat_clr && !wrap) |=> !dly_msb);
endmodule

// File: tb/sim_tx_slip_buffer.sv
`timescale 1ns/1ps
module sim_tx_slip_buffer;
  localparam int SLOTS = 32, CHANS = 24, MARGIN = 2;
  localparam int FRB   = SLOTS * 8;
  localparam int RING  = 2 * FRB;
  localparam int RUNF  = 50;
  localparam int NSC   = 3;
  // {transmit half period in ps, expected slips: 0 drop, 1 repeat, 2 none}
  localparam int TAB [NSC][2] = '{'{6300, 1}, '{6632, 2}, '{6880, 0}};

  logic sys_clk = 0, tx_clk = 0, sys_rst_n = 0, tx_rst_n = 0;
  logic sys_data = 0, stat_clr = 0;
  logic [4:0] dly_slots; logic [2:0] dly_bits; logic dly_msb;
  logic tx_data, tx_fslot, slip_tog, slip_rep;
  real  txh = 6.632;

  tx_slip_buffer #(.SLOTS(SLOTS), .CHANS(CHANS), .MARGIN(MARGIN)) u0 (
    .sys_clk, .sys_rst_n, .sys_data, .stat_clr, .dly_slots, .dly_bits, .dly_msb,
    .tx_clk, .tx_rst_n, .tx_data, .tx_fslot, .slip_tog, .slip_rep);

  always #5 sys_clk = ~sys_clk;
  always #(txh) tx_clk = ~tx_clk;

  int checks = 0, errors = 0, cyc = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge sys_clk) begin
    cyc++;
    if (cyc == 190000) begin
      chk(0, "watchdog", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  bit run = 0;
  int wb = 0, p_raw, last_p, last_exp, fpos, nfr, nrep, ndrop;
  bit prev_tog, prev_dir, slipped, cur_dir, fok;
  logic [7:0] sh;
  logic [2:0] ftag, ptag;

  always @(negedge tx_clk) if (run) begin
    if (tx_fslot) begin
      p_raw   = wb;
      slipped = (slip_tog != prev_tog);
      if (!slipped) chk(slip_rep == prev_dir, "R6 direction held without slip", slip_rep, prev_dir);
      prev_tog = slip_tog; prev_dir = slip_rep; cur_dir = slip_rep;
      fpos = 0; fok = 1;
    end else if (fpos < CHANS * 8) begin
      int ch;
      sh = {sh[6:0], tx_data};
      fpos++;
      if (fpos % 8 == 0) begin
        ch = fpos / 8 - 1;
        if (int'(sh[4:0]) != ch) fok = 0;
        if (ch == 0) begin
          ftag = sh[7:5];
          if (nfr > 0) begin
            last_p   = p_raw;
            last_exp = ((p_raw - int'(ftag[0]) * FRB) % RING + RING) % RING;
          end
        end else if (sh[7:5] != ftag) fok = 0;
        if (ch == CHANS - 1) begin
          if (nfr > 0) chk(fok, "R2 frame content", fok, 1);
          if (nfr > 1) begin
            int diff;
            diff = int'(ftag - ptag) & 7;
            if (slipped && cur_dir) begin
              chk(diff == 0, "R3 R5 repeated frame", diff, 0); nrep++;
            end else if (slipped) begin
              chk(diff == 2, "R4 R5 dropped frame", diff, 2); ndrop++;
            end else chk(diff == 1, "R5 next frame without slip", diff, 1);
          end
          ptag = ftag;
          nfr++;
        end
      end
    end
  end

  initial begin
    for (int s = 0; s < NSC; s++) begin
      int clr_k, npub, snap;
      sys_rst_n = 0; tx_rst_n = 0; run = 0; stat_clr = 0; sys_data = 0;
      txh = TAB[s][0] / 1000.0;
      nfr = 0; nrep = 0; ndrop = 0; prev_tog = 0; prev_dir = 0;
      p_raw = -1000; last_p = -2000; last_exp = 0; fpos = CHANS * 8;
      clr_k = -10; npub = 0; snap = 0;
      repeat (4) @(negedge sys_clk);
      // R1 reset state
      chk(tx_fslot == 1 && tx_data == 0, "R1 framing position in reset", tx_fslot, 1);
      chk(slip_tog == 0 && slip_rep == 0, "R1 slip flags in reset", {slip_tog, slip_rep}, 0);
      chk({dly_msb, dly_slots, dly_bits} == 0, "R1 delay fields in reset",
          int'({dly_msb, dly_slots, dly_bits}), 0);
      sys_rst_n = 1; tx_rst_n = 1; run = 1;
      for (int k = 0; k < RUNF * FRB; k++) begin
        logic [7:0] byt;
        int act;
        wb  = k;
        act = int'({dly_msb, dly_slots, dly_bits});
        if (k == clr_k + 1) begin
          stat_clr = 0;
          chk(dly_msb == 0, "R9 MSB cleared by host write", dly_msb, 0);
          chk(act == (snap & 255), "R9 slot and bit fields kept", act, snap & 255);
          snap = snap & 255;
        end
        if (k > 0 && k % RING == 0) begin
          if (last_p == p_raw && k - p_raw >= 8 && nfr > 1) begin
            chk(((act - last_exp) % RING + RING) % RING <= 4, "R7 R9 published delay", act, last_exp);
            npub++;
          end
          snap = act;
          if (TAB[s][1] == 0 && dly_msb && clr_k < 0) begin
            stat_clr = 1; clr_k = k;
          end
        end
        if (k >= RING && k % RING == RING / 2)
          chk(act == snap, "R8 fields hold between publications", act, snap);
        byt = {3'((k / FRB) % 8), 5'((k / 8) % SLOTS)};
        sys_data = byt[7 - k % 8];
        @(negedge sys_clk);
      end
      run = 0;
      chk(npub >= 5, "R7 publications observed", npub, 5);
      case (TAB[s][1])
        1: begin
          chk(nrep >= 1, "R3 fast clock repeats a frame", nrep, 1);
          chk(ndrop == 0, "R3 fast clock never drops", ndrop, 0);
        end
        0: begin
          chk(ndrop >= 1, "R4 slow clock drops a frame", ndrop, 1);
          chk(nrep == 0, "R4 slow clock never repeats", nrep, 0);
          chk(clr_k >= 0, "R9 MSB seen set before clear", clr_k, 0);
        end
        default: chk(nrep + ndrop == 0, "R10 matched rates no slip", nrep + ndrop, 0);
      endcase
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule